// File: doc/BRIEF.md
# Length-8 Polar Successive-Cancellation Decoder

This block recovers the eight source bits of a length-8 polar codeword from eight signed channel log-likelihood ratios. A positive LLR favours a transmitted 0. Decoding is successive cancellation over three levels of processing. The top level combines the four channel pairs (k, k+4), the middle level combines pairs (j, j+2) of its four inputs, and the leaf level produces the bit LLRs. Each level offers a check-type update f, which is min-sum, and a bit-type update g, which is a signed sum. The sign of the g update is steered by partial sums of the bits already decided.

A caller drives the LLRs, a frozen-position mask and a mode select, then pulses `start`. The block latches all three on that edge. It then walks a fixed schedule and fills `dec_bits`, with bit k-1 holding û_k, in the order û1 to û8. `done` is raised for one cycle on the edge that writes û8. There are two schedules. The tree schedule visits one node per cycle. The merged schedule uses a leaf element that computes both g candidates next to the f result, picks one with the bit that was just decided, and chains that pair decision behind the middle level. The merged schedule finishes in less than half the cycles of the tree schedule.

Top module: `polar_sc_decoder`

## Requirements
- R1: After reset, `busy`, `done` and `dec_bits` are all 0.
- R2: For a noise-free codeword x = u·F⊗3, each channel LLR is +M when x_k = 0 and -M when x_k = 1. Channel y_k sits at bits [6k+5:6k] of `llr_in`. With no frozen positions, `dec_bits` equals u in both modes, with û_k in bit k-1.
- R3: A non-frozen bit is decided 1 only when its final LLR is negative. An LLR of exactly zero gives 0, so an all-zero `llr_in` decodes to 8'h00.
- R4: When bit k-1 of the mask latched at start is 1, û_k is 0 whatever the LLRs say. Later decisions use that 0 in their partial sums.
- R5: For arbitrary 6-bit LLRs, the decisions match successive cancellation in which f(a,b) = sign(a)·sign(b)·min(|a|,|b|) and g(a,b,s) = b + (-1)^s·a. Internal values saturate symmetrically at ±127 on 8 bits.
- R6: With `merged_mode` = 0 at start, `done` is high in the cycle after the 14th rising edge that follows the accepting edge. `busy` is high from the accepting edge until that point and low while `done` is high.
- R7: With `merged_mode` = 1 at start, `done` follows the accepting edge by 6 rising edges.
- R8: `done` is high for exactly one cycle per decode.
- R9: A `start` pulse, a new `merged_mode` or new LLRs applied while `busy` is high have no effect on the running decode's result or its cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a decode; ignored while busy |
| merged_mode | input | 1 | 0 = tree schedule, 1 = merged schedule; sampled at start |
| llr_in | input | 48 | Eight signed 6-bit channel LLRs, y_k at [6k+5:6k] |
| frozen_mask | input | 8 | Bit k-1 set forces û_k to 0; sampled at start |
| busy | output | 1 | A decode is in progress |
| done | output | 1 | One-cycle pulse when û8 has been written |
| dec_bits | output | 8 | Decided bits, û_k in bit k-1 |

## Verification
The bench sweeps all 256 information words through both schedules. A wrong partial-sum order or a swapped pair split in either level would corrupt the later bits for many of these patterns. It also feeds random noisy LLRs with random masks against an independently written level-by-level model. This exposes a flipped g sign, a min-sum sign error, or a frozen bit whose forced 0 is not carried into later partial sums. All-zero LLRs catch a decision rule that treats zero as negative. A start pulse with altered LLRs and mode in mid-decode, together with exact cycle counts and a one-cycle `done`, shows up any schedule that restarts, stretches or uses the wrong mode.

// File: rtl/polar_sc_pkg.sv
package polar_sc_pkg;
  localparam int N          = 8;
  localparam int LAT_TREE   = 2 * (N - 1);
  localparam int LAT_MERGED = N - 2;
  localparam int STEP_W     = $clog2(LAT_TREE + 1);
  localparam int BPTR_W     = $clog2(N);

  typedef enum logic [2:0] {
    OP_F3, OP_G3, OP_F2, OP_G2, OP_F1, OP_G1, OP_M2F, OP_M2G
  } op_e;

  // Node visited at each step of the two schedules.
  function automatic op_e sched_op(input logic merged, input logic [STEP_W-1:0] step);
    op_e o;
    if (merged) begin
      case (step)
        0:       o = OP_F3;
        1:       o = OP_M2F;
        2:       o = OP_M2G;
        3:       o = OP_G3;
        4:       o = OP_M2F;
        default: o = OP_M2G;
      endcase
    end else begin
      case (step)
        0:       o = OP_F3;
        1:       o = OP_F2;
        2:       o = OP_F1;
        3:       o = OP_G1;
        4:       o = OP_G2;
        5:       o = OP_F1;
        6:       o = OP_G1;
        7:       o = OP_G3;
        8:       o = OP_F2;
        9:       o = OP_F1;
        10:      o = OP_G1;
        11:      o = OP_G2;
        12:      o = OP_F1;
        default: o = OP_G1;
      endcase
    end
    return o;
  endfunction
endpackage

// File: rtl/polar_sc_stage.sv
module polar_sc_stage #(
  parameter int HALF  = 4,
  parameter int INT_W = 8
) (
  input  logic [HALF-1:0][INT_W-1:0] a_llr,
  input  logic [HALF-1:0][INT_W-1:0] b_llr,
  input  logic [HALF-1:0]            psum,
  output logic [HALF-1:0][INT_W-1:0] f_llr,
  output logic [HALF-1:0][INT_W-1:0] g_llr
);
  localparam logic signed [INT_W+1:0] LIM = (INT_W+2)'(2**(INT_W-1) - 1);
  localparam logic signed [INT_W+1:0] NLIM = -LIM;

  function automatic logic [INT_W-1:0] clip(input logic signed [INT_W+1:0] v);
    if (v > LIM)       return LIM[INT_W-1:0];
    else if (v < NLIM) return NLIM[INT_W-1:0];
    else               return v[INT_W-1:0];
  endfunction

  function automatic logic [INT_W-1:0] minsum(input logic signed [INT_W-1:0] la,
                                              input logic signed [INT_W-1:0] lb);
    logic [INT_W-1:0] ma, mb, m;
    ma = la[INT_W-1] ? -la : la;
    mb = lb[INT_W-1] ? -lb : lb;
    m  = (ma < mb) ? ma : mb;
    return (la[INT_W-1] ^ lb[INT_W-1]) ? -m : m;
  endfunction

  function automatic logic [INT_W-1:0] gupd(input logic signed [INT_W-1:0] la,
                                            input logic signed [INT_W-1:0] lb,
                                            input logic s);
    logic signed [INT_W+1:0] wa, wb;
    wa = (INT_W+2)'(la);
    wb = (INT_W+2)'(lb);
    return clip(s ? (wb - wa) : (wb + wa));
  endfunction

  for (genvar j = 0; j < HALF; j++) begin : g_lane
    assign f_llr[j] = minsum(a_llr[j], b_llr[j]);
    assign g_llr[j] = gupd(a_llr[j], b_llr[j], psum[j]);
  end
endmodule

// File: rtl/polar_sc_leaf.sv
module polar_sc_leaf #(
  parameter int INT_W = 8
) (
  input  logic [1:0][INT_W-1:0] pair_llr,
  input  logic                  frz_odd,
  input  logic                  frz_even,
  output logic                  bit_odd,
  output logic                  bit_even
);
  logic [1:0][INT_W-1:0] f_c;
  logic [1:0][INT_W-1:0] g_c;

  // Both g candidates side by side; the odd decision selects one.
  for (genvar c = 0; c < 2; c++) begin : g_cand
    polar_sc_stage #(.HALF(1), .INT_W(INT_W)) u_pe (
      .a_llr (pair_llr[0]),
      .b_llr (pair_llr[1]),
      .psum  (1'(c)),
      .f_llr (f_c[c]),
      .g_llr (g_c[c])
    );
  end

  logic [INT_W-1:0] even_llr;
  assign bit_odd  = !frz_odd && f_c[0][INT_W-1];
  assign even_llr = bit_odd ? g_c[1] : g_c[0];
  assign bit_even = !frz_even && even_llr[INT_W-1];
endmodule

// File: rtl/polar_sc_sched.sv
module polar_sc_sched
  import polar_sc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              merged_mode,
  output logic              busy,
  output logic              done,
  output logic              accept,
  output logic              run_mode,
  output logic [STEP_W-1:0] step_idx,
  output op_e               op
);
  logic [STEP_W-1:0] last_step;

  assign accept    = start && !busy;
  assign last_step = run_mode ? STEP_W'(LAT_MERGED - 1) : STEP_W'(LAT_TREE - 1);
  assign op        = sched_op(run_mode, step_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      run_mode <= 1'b0;
      step_idx <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        run_mode <= merged_mode;
        step_idx <= '0;
      end else if (busy) begin
        step_idx <= step_idx + 1'b1;
        if (step_idx == last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/polar_sc_decoder.sv
module polar_sc_decoder
  import polar_sc_pkg::*;
#(
  parameter int LLR_W = 6,
  parameter int INT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               merged_mode,
  input  logic [N*LLR_W-1:0] llr_in,
  input  logic [N-1:0]       frozen_mask,
  output logic               busy,
  output logic               done,
  output logic [N-1:0]       dec_bits
);
  localparam int Q = N / 4;
  localparam int H = N / 2;

  logic              accept, run_mode;
  logic [STEP_W-1:0] step_idx;
  op_e               op;

  polar_sc_sched u_sched (
    .clk, .rst_n, .start, .merged_mode,
    .busy, .done, .accept, .run_mode, .step_idx, .op
  );

  logic [N-1:0][INT_W-1:0] ch_in, ch;
  logic [H-1:0][INT_W-1:0] l2, f3v, g3v;
  logic [Q-1:0][INT_W-1:0] l1, f2v, g2v, leaf_in;
  logic [N-1:0]            u, frozen_q;
  logic [BPTR_W-1:0]       bptr, pb;
  logic [H-1:0]            s4;
  logic [Q-1:0]            t2;
  logic                    bit_odd, bit_even;

  for (genvar k = 0; k < N; k++) begin : g_ext
    assign ch_in[k] = {{(INT_W-LLR_W){llr_in[k*LLR_W+LLR_W-1]}}, llr_in[k*LLR_W +: LLR_W]};
  end

  // Partial sums: first half re-encoded for the top g, last pair for the middle g.
  assign s4 = {u[3], u[2]^u[3], u[1]^u[3], u[0]^u[1]^u[2]^u[3]};
  assign t2 = {u[bptr-BPTR_W'(1)], u[bptr-BPTR_W'(2)] ^ u[bptr-BPTR_W'(1)]};
  assign pb = {bptr[BPTR_W-1:1], 1'b0};

  polar_sc_stage #(.HALF(H), .INT_W(INT_W)) u_top (
    .a_llr(ch[H-1:0]), .b_llr(ch[N-1:H]), .psum(s4), .f_llr(f3v), .g_llr(g3v)
  );

  polar_sc_stage #(.HALF(Q), .INT_W(INT_W)) u_mid (
    .a_llr(l2[Q-1:0]), .b_llr(l2[H-1:Q]), .psum(t2), .f_llr(f2v), .g_llr(g2v)
  );

  always_comb begin
    case (op)
      OP_M2F:  leaf_in = f2v;
      OP_M2G:  leaf_in = g2v;
      default: leaf_in = l1;
    endcase
  end

  polar_sc_leaf #(.INT_W(INT_W)) u_leaf (
    .pair_llr(leaf_in), .frz_odd(frozen_q[pb]), .frz_even(frozen_q[pb+BPTR_W'(1)]),
    .bit_odd, .bit_even
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch       <= '0;
      l2       <= '0;
      l1       <= '0;
      u        <= '0;
      bptr     <= '0;
      frozen_q <= '0;
    end else if (accept) begin
      ch       <= ch_in;
      u        <= '0;
      bptr     <= '0;
      frozen_q <= frozen_mask;
    end else if (busy) begin
      case (op)
        OP_F3: l2 <= f3v;
        OP_G3: l2 <= g3v;
        OP_F2: l1 <= f2v;
        OP_G2: l1 <= g2v;
        OP_F1: begin
          u[pb] <= bit_odd;
          bptr  <= bptr + BPTR_W'(1);
        end
        OP_G1: begin
          u[pb+BPTR_W'(1)] <= bit_even;
          bptr             <= bptr + BPTR_W'(1);
        end
        default: begin
          u[pb]            <= bit_odd;
          u[pb+BPTR_W'(1)] <= bit_even;
          bptr             <= bptr + BPTR_W'(2);
        end
      endcase
    end
  end

  assign dec_bits = u;
endmodule

// File: rtl/polar_sc_checker.sv
module polar_sc_checker
  import polar_sc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              run_mode,
  input logic [STEP_W-1:0] step_idx,
  input logic [N-1:0]      frozen_q,
  input logic [N-1:0]      dec_bits
);
  logic [7:0] cyc;
  always_ff @(posedge clk) begin
    if (!rst_n)              cyc <= '0;
    else if (start && !busy) cyc <= '0;
    else if (busy)           cyc <= cyc + 8'd1;
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_tree_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !run_mode) |-> cyc == 8'(LAT_TREE));
  assert_merged_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && run_mode) |-> cyc == 8'(LAT_MERGED));
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_frozen_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dec_bits & frozen_q) == '0);
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> step_idx == $past(step_idx) + 1'b1);
endmodule

bind polar_sc_decoder polar_sc_checker i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .run_mode(run_mode), .step_idx(step_idx), .frozen_q(frozen_q), .dec_bits(dec_bits)
);

// File: tb/test_polar_sc_decoder.sv
module test_polar_sc_decoder;
  localparam int NB = 8;
  localparam int LW = 6;
  localparam int MAG = 9;

  logic clk = 0, rst_n = 0, start = 0, merged_mode = 0;
  logic [NB*LW-1:0] llr_in = '0;
  logic [NB-1:0] frozen_mask = '0;
  logic busy, done;
  logic [NB-1:0] dec_bits;
  int compared = 0, mismatched = 0;

  always #4 clk = ~clk;

  polar_sc_decoder i_polar_sc_decoder (
    .clk, .rst_n, .start, .merged_mode, .llr_in, .frozen_mask, .busy, .done, .dec_bits
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] encode(input logic [7:0] v, input int n);
    logic [7:0] x = v;
    for (int h = 1; h < n; h = h * 2)
      for (int i = 0; i < n; i++)
        if ((i & h) == 0) x[i] = x[i] ^ x[i+h];
    return x;
  endfunction

  function automatic int fmin(input int a, input int b);
    int m = ((a < 0) ? -a : a) < ((b < 0) ? -b : b) ? ((a < 0) ? -a : a) : ((b < 0) ? -b : b);
    return ((a < 0) != (b < 0)) ? -m : m;
  endfunction

  // Level-by-level walk to the LLR of bit k, halving the span each level.
  function automatic int bit_llr(input int y[8], input int k, input logic [7:0] u);
    int cur[8], nxt[8];
    int n = 8, off = 0, h;
    logic [7:0] s;
    cur = y;
    while (n > 1) begin
      h = n / 2;
      if (k - off < h) begin
        for (int j = 0; j < h; j++) nxt[j] = fmin(cur[j], cur[j+h]);
      end else begin
        s = encode(u >> off, h);
        for (int j = 0; j < h; j++) nxt[j] = cur[j+h] + (s[j] ? -cur[j] : cur[j]);
        off = off + h;
      end
      cur = nxt;
      n = h;
    end
    return cur[0];
  endfunction

  function automatic logic [7:0] ref_decode(input logic [NB*LW-1:0] lv, input logic [7:0] msk);
    int y[8];
    logic [7:0] u = '0;
    for (int k = 0; k < 8; k++) y[k] = int'($signed(lv[k*LW +: LW]));
    for (int k = 0; k < 8; k++) u[k] = !msk[k] && (bit_llr(y, k, u) < 0);
    return u;
  endfunction

  function automatic logic [NB*LW-1:0] clean_llr(input logic [7:0] u);
    logic [7:0] x = encode(u, 8);
    logic [NB*LW-1:0] v;
    for (int k = 0; k < 8; k++) v[k*LW +: LW] = x[k] ? LW'(-MAG) : LW'(MAG);
    return v;
  endfunction

  task automatic run(input bit md, input logic [NB*LW-1:0] lv, input logic [7:0] msk,
                     input bit disturb, output logic [7:0] got, output int lat);
    @(negedge clk);
    merged_mode = md; llr_in = lv; frozen_mask = msk; start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    lat = 0;
    while (!done && lat < 40) begin
      if (disturb && lat == 3) begin
        start = 1; llr_in = ~lv; merged_mode = ~md; frozen_mask = ~msk;
      end else start = 0;
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    start = 0;
    got = dec_bits;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] got, exp, uu, mm;
    logic [NB*LW-1:0] lv;
    int lat;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 dec_bits", dec_bits, 0);

    // R2 exhaustive clean codewords, both schedules; R6/R7 cycle counts.
    for (int md = 0; md < 2; md++)
      for (int w = 0; w < 256; w++) begin
        run(md[0], clean_llr(w[7:0]), 8'h00, 0, got, lat);
        check("R2 clean recovery", got, w);
        check(md ? "R7 merged latency" : "R6 tree latency", lat, md ? 6 : 14);
      end

    // R8 done lasts one cycle; R6 busy low with done.
    run(0, clean_llr(8'hA5), 8'h00, 0, got, lat);
    check("R6 busy low at done", busy, 0);
    @(negedge clk);
    check("R8 done one cycle", done, 0);

    // R3 zero LLR decides 0.
    for (int md = 0; md < 2; md++) begin
      run(md[0], '0, 8'h00, 0, got, lat);
      check("R3 zero llr", got, 0);
    end

    // R4 frozen positions forced to 0 against LLRs that say 1.
    for (int md = 0; md < 2; md++) begin
      run(md[0], clean_llr(8'hFF), 8'hFF, 0, got, lat);
      check("R4 all frozen", got, 0);
      for (int t = 0; t < 20; t++) begin
        uu = 8'($urandom);
        run(md[0], clean_llr(uu), 8'h17, 0, got, lat);
        check("R4 mask 17", got, ref_decode(clean_llr(uu), 8'h17));
      end
    end

    // R5 noisy LLRs with random masks against the reference walk.
    for (int t = 0; t < 300; t++) begin
      for (int k = 0; k < 8; k++) lv[k*LW +: LW] = LW'($urandom_range(0, 63));
      mm = 8'($urandom) & 8'($urandom);
      exp = ref_decode(lv, mm);
      run(t[0], lv, mm, 0, got, lat);
      check("R5 noisy decode", got, exp);
    end

    // R9 start, mode and LLR changes mid-decode are ignored.
    for (int md = 0; md < 2; md++) begin
      run(md[0], clean_llr(8'h3C), 8'h00, 1, got, lat);
      check("R9 result kept", got, 8'h3C);
      check("R9 latency kept", lat, md ? 6 : 14);
      @(negedge clk);
      check("R9 no restart", busy, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule